// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor and a word-wide main memory and keeps 64 KB of recently used data close to the processor. Storage is organised as 4096 lines. Each line holds one valid flag, a 16-bit tag and a block of four 32-bit words. Every memory block has exactly one home line, chosen by the block address modulo the line count. A lookup is combinational: the processor learns in the same cycle whether the access hits.

Reads that miss stall the processor. The controller then fetches the four words of the block from memory in ascending order, installs the tag and releases the processor on the following lookup. Every store is written through to memory. A store that hits updates its word in the line when memory accepts the write. A store that misses first brings in the whole block and then performs the store as a hit. There is no write buffer, so the processor also waits for memory on a store hit.

The processor holds its request (strobe, address and write data) stable while stall is high. A request completes in the cycle in which a strobe is high and stall is low. A memory transfer takes place in any cycle in which both the request and ready signals are high. Read data from memory is valid in that same cycle.

Top module: `dmwt_cache`

## Requirements
- R1: The byte address splits into tag = bits 31..16, line index = bits 15..4, word select = bits 3..2 and byte select = bits 1..0. The byte select has no effect on lookup or on the returned word.
- R2: A read whose line is valid and whose stored tag equals the address tag completes in its first cycle: stall low, hit high, and read data equal to the word picked by the word select.
- R3: A read miss raises stall in its first cycle and keeps it high through the refill. The read then completes with the memory's word. With a memory that waits L cycles before each ready, the stall lasts 1 + 4(L+1) cycles.
- R4: A refill issues four word reads (write enable low) at block base + 0x0, 0x4, 0x8 and 0xC, in that order.
- R5: A store that hits issues exactly one memory write with the word-aligned address and the store data. Stall stays high until memory accepts that write (L cycles). The cache word reads back as the new value afterwards.
- R6: A store that misses refills the block and then writes the store word to the line and to memory. The stall lasts 1 + 4(L+1) + L cycles, and the other words of the block hit afterwards.
- R7: Two blocks that share a line index evict each other: after the second is loaded, the first misses again.
- R8: Reset clears every valid flag, so an address that hit before reset misses after it. With no access pending, stall, hit and the memory request are low.
- R9: Reads never cause memory writes, and the memory request is low while the cache is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe (wins over read) |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor store data |
| cpu_rdata | output | 32 | Selected word of the addressed line |
| cpu_hit | output | 1 | Lookup hit for the current access |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts / delivers in this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
A store hit updates the line word in the same cycle that memory accepts the write-through, and these two events must always coincide. The bench provokes this by running a memory model that holds ready low for three cycles before each transfer. It then checks that the store stalls exactly three cycles, that the memory log holds one write with the right address and data, and that the word reads back. The same model is used to time a store miss, where the last refill beat and the installation of the tag are followed at once by the write-through of the store.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;

  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } ctl_state_e;

endpackage

// File: rtl/dmwt_tag_store.sv
module dmwt_tag_store #(
  parameter int TAG_W   = 16,
  parameter int INDEX_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_index,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [TAG_W-1:0]   wr_tag
);

  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // valid flags are the only state that needs a reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_index] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_index] <= wr_tag;
    end
  end

  assign rd_valid = valid_q[rd_index];
  assign rd_tag   = tag_q[rd_index];

  AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (rd_index == wr_index) |=> rd_valid || (rd_index != $past(wr_index)));  // R3

endmodule

// File: rtl/dmwt_data_store.sv
module dmwt_data_store #(
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 2,
  parameter int INDEX_W = 12
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [OFF_W-1:0]   wr_word,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [INDEX_W-1:0] rd_index,
  input  logic [OFF_W-1:0]   rd_word,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int LINES = 1 << INDEX_W;
  localparam int WORDS = 1 << OFF_W;

  logic [DATA_W-1:0] bank_rd [WORDS];

  // one word-wide bank per word position; the word select steers writes
  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [DATA_W-1:0] bank_q [LINES];
    logic              bank_we;

    assign bank_we = wr_en && (wr_word == OFF_W'(w));

    always_ff @(posedge clk) begin
      if (bank_we) begin
        bank_q[wr_index] <= wr_data;
      end
    end

    assign bank_rd[w] = bank_q[rd_index];
  end

  // word multiplexer driven by the block offset
  assign rd_data = bank_rd[rd_word];

endmodule

// File: rtl/dmwt_ctrl.sv
module dmwt_ctrl
  import dmwt_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic             lookup_hit,
  input  logic             mem_ready,
  output logic             stall,
  output logic             mem_req,
  output logic             mem_we,
  output logic             refilling,
  output logic             fill_beat,
  output logic             fill_last,
  output logic             store_en,
  output logic [OFF_W-1:0] fill_word
);

  localparam logic [OFF_W-1:0] LAST_WORD = '1;

  ctl_state_e       state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    stall     = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    fill_beat = 1'b0;
    fill_last = 1'b0;
    store_en  = 1'b0;
    case (state_q)
      ST_LOOKUP: begin
        if (acc_rd || acc_wr) begin
          if (!lookup_hit) begin
            stall   = 1'b1;
            state_d = ST_REFILL;
            cnt_en  = 1'b1;
            cnt_d   = '0;
          end else if (acc_wr) begin
            // write-through with no buffer: wait for memory acceptance
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            stall    = !mem_ready;
            store_en = mem_ready;
          end
        end
      end
      ST_REFILL: begin
        mem_req = 1'b1;
        stall   = 1'b1;
        if (mem_ready) begin
          fill_beat = 1'b1;
          cnt_en    = 1'b1;
          cnt_d     = cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) begin
            fill_last = 1'b1;
            state_d   = ST_LOOKUP;
          end
        end
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOOKUP;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign refilling = (state_q == ST_REFILL);
  assign fill_word = cnt_q;

  AST_REFILL_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    refilling && mem_ready && (fill_word != LAST_WORD) |=> refilling && stall);  // R3

  AST_REFILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    refilling && !mem_ready |=> refilling && $stable(fill_word));  // R4

endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 12,
  parameter int OFF_W   = 2,
  parameter int BYTE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int TAG_W = ADDR_W - INDEX_W - OFF_W - BYTE_W;
  localparam logic [OFF_W-1:0] LAST_WORD = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  // address fields
  logic [TAG_W-1:0]   addr_tag;
  logic [INDEX_W-1:0] addr_index;
  logic [OFF_W-1:0]   addr_word;
  logic [BYTE_W-1:0]  unused_byte_sel;

  assign addr_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
  assign addr_index      = cpu_addr[BYTE_W+OFF_W +: INDEX_W];
  assign addr_word       = cpu_addr[BYTE_W +: OFF_W];
  assign unused_byte_sel = cpu_addr[BYTE_W-1:0];

  logic               line_valid;
  logic [TAG_W-1:0]   line_tag;
  logic               lookup_hit;
  logic               access;
  logic               refilling;
  logic               fill_beat;
  logic               fill_last;
  logic               store_en;
  logic [OFF_W-1:0]   fill_word;
  logic               ds_we;
  logic [OFF_W-1:0]   ds_word;
  logic [DATA_W-1:0]  ds_wdata;

  assign access     = cpu_rd || cpu_wr;
  assign lookup_hit = line_valid && (line_tag == addr_tag);

  dmwt_tag_store #(
    .TAG_W   (TAG_W),
    .INDEX_W (INDEX_W)
  ) i_tags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_index (addr_index),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .wr_en    (fill_last),
    .wr_index (addr_index),
    .wr_tag   (addr_tag)
  );

  // refill beats take the memory word, store hits take the processor word
  assign ds_we    = fill_beat || store_en;
  assign ds_word  = fill_beat ? fill_word : addr_word;
  assign ds_wdata = fill_beat ? mem_rdata : cpu_wdata;

  dmwt_data_store #(
    .DATA_W  (DATA_W),
    .OFF_W   (OFF_W),
    .INDEX_W (INDEX_W)
  ) i_data (
    .clk      (clk),
    .wr_en    (ds_we),
    .wr_index (addr_index),
    .wr_word  (ds_word),
    .wr_data  (ds_wdata),
    .rd_index (addr_index),
    .rd_word  (addr_word),
    .rd_data  (cpu_rdata)
  );

  dmwt_ctrl #(
    .OFF_W (OFF_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .acc_rd     (cpu_rd),
    .acc_wr     (cpu_wr),
    .lookup_hit (lookup_hit),
    .mem_ready  (mem_ready),
    .stall      (cpu_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .refilling  (refilling),
    .fill_beat  (fill_beat),
    .fill_last  (fill_last),
    .store_en   (store_en),
    .fill_word  (fill_word)
  );

  assign cpu_hit   = access && lookup_hit && !refilling;
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = refilling ? {addr_tag, addr_index, fill_word, {BYTE_W{1'b0}}}
                               : {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};

  AST_DONE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    access && !cpu_stall |-> cpu_hit);  // R2

  AST_MISS_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    access && !refilling && !cpu_hit |=> mem_req && !mem_we && (mem_addr[BYTE_W +: OFF_W] == '0));  // R4

  AST_FILL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && mem_ready && !mem_we && (mem_addr[BYTE_W +: OFF_W] != LAST_WORD)
    |=> mem_req && !mem_we && (mem_addr[BYTE_W +: OFF_W] == OFF_W'($past(mem_addr[BYTE_W +: OFF_W]) + 1'b1)));  // R4

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && mem_ready && !mem_we && (mem_addr[BYTE_W +: OFF_W] == LAST_WORD) |=> cpu_hit);  // R3

  AST_STORE_DONE_WITH_MEM: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_wr && !cpu_stall |-> mem_req && mem_we && mem_ready);  // R5

  AST_READ_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_rd && !cpu_wr |-> !(mem_req && mem_we));  // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    !access && !refilling |-> !mem_req && !cpu_stall);  // R9

endmodule

// File: tb/test_dmwt_cache.sv
`timescale 1ns/100ps
module test_dmwt_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_hit;
  logic        cpu_stall;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  dmwt_cache i_dmwt_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_hit   (cpu_hit),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory content before any store
  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16]};
  endfunction

  // memory model with programmable wait before each ready
  logic [31:0] mem_store [logic [31:0]];
  int          mem_lat = 0;
  int          wait_cnt = 0;
  int          wr_log_n = 0;
  logic [31:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  int          rd_log_n = 0;
  logic [31:0] rd_log [16];

  always @(negedge clk) begin
    #1;
    if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_ready = 1'b1;
        wait_cnt  = 0;
        if (mem_we) begin
          mem_store[mem_addr] = mem_wdata;
          wr_log_n++;
          last_wr_addr = mem_addr;
          last_wr_data = mem_wdata;
        end else begin
          mem_rdata = mem_store.exists(mem_addr) ? mem_store[mem_addr] : pat(mem_addr);
          if (rd_log_n < 16) rd_log[rd_log_n] = mem_addr;
          rd_log_n++;
        end
      end else begin
        mem_ready = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end
  end

  // expected memory view, updated from the bench's own stores
  logic [31:0] ref_mem [logic [31:0]];

  function automatic logic [31:0] ref_val(input logic [31:0] a);
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    return ref_mem.exists(wa) ? ref_mem[wa] : pat(wa);
  endfunction

  task automatic do_access(input logic w, input logic [31:0] a, input logic [31:0] d,
                           output logic [31:0] rdat, output int cyc, output logic hit0);
    @(negedge clk);
    cpu_wr    = w;
    cpu_rd    = !w;
    cpu_addr  = a;
    cpu_wdata = d;
    cyc = 0;
    #2;
    hit0 = cpu_hit;
    while (cpu_stall) begin
      cyc++;
      @(negedge clk);
      #2;
    end
    rdat = cpu_rdata;
    if (w) ref_mem[{a[31:2], 2'b00}] = d;
    @(posedge clk);
    #1;
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [7:0]  stall;
  } vec_t;

  localparam int NV = 13;
  // stall counts for a memory with no wait: miss = 5, hit = 0
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0001_0010, 32'h0000_0000, 8'd5},  // cold read miss
    '{1'b0, 32'h0001_001C, 32'h0000_0000, 8'd0},  // same block hits
    '{1'b1, 32'h0001_0014, 32'hDEAD_0001, 8'd0},  // store hit
    '{1'b0, 32'h0001_0014, 32'h0000_0000, 8'd0},  // reads stored word
    '{1'b0, 32'h0002_0010, 32'h0000_0000, 8'd5},  // same index, other tag (R7)
    '{1'b0, 32'h0001_0014, 32'h0000_0000, 8'd5},  // evicted block misses, memory has store
    '{1'b1, 32'h0003_0028, 32'hBEEF_0002, 8'd5},  // store miss
    '{1'b0, 32'h0003_0028, 32'h0000_0000, 8'd0},
    '{1'b0, 32'h0003_0020, 32'h0000_0000, 8'd0},  // rest of block installed
    '{1'b0, 32'hFFFF_FFF0, 32'h0000_0000, 8'd5},  // top line index
    '{1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 8'd0},
    '{1'b0, 32'h0000_0003, 32'h0000_0000, 8'd5},  // byte select set (R1)
    '{1'b0, 32'h0000_0000, 32'h0000_0000, 8'd0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rdat;
    int          cyc;
    logic        hit0;
    int          wsnap;
    string       tag;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R8: idle outputs after reset
    @(negedge clk); #2;
    chk(cpu_stall == 1'b0, "R8", "stall after reset", {31'd0, cpu_stall}, 32'd0);
    chk(cpu_hit == 1'b0, "R8", "hit after reset", {31'd0, cpu_hit}, 32'd0);
    chk(mem_req == 1'b0, "R9", "mem_req while idle", {31'd0, mem_req}, 32'd0);

    // table walk, memory with no wait
    for (int i = 0; i < NV; i++) begin
      do_access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rdat, cyc, hit0);
      if (VECS[i].stall == 0) tag = VECS[i].wr ? "R5" : "R2";
      else                    tag = VECS[i].wr ? "R6" : "R3";
      chk(cyc == int'(VECS[i].stall), tag, $sformatf("vec %0d stall cycles", i),
          cyc, {24'd0, VECS[i].stall});
      chk(hit0 == (VECS[i].stall == 0), tag, $sformatf("vec %0d first-cycle hit", i),
          {31'd0, hit0}, {31'd0, VECS[i].stall == 0});
      if (!VECS[i].wr)
        chk(rdat == ref_val(VECS[i].addr), tag, $sformatf("vec %0d read data", i),
            rdat, ref_val(VECS[i].addr));
    end

    // R1: byte select ignored, same word as the aligned address
    do_access(1'b0, 32'h0000_0002, 32'h0, rdat, cyc, hit0);
    chk(cyc == 0 && rdat == ref_val(32'h0), "R1", "byte select ignored", rdat, ref_val(32'h0));

    // R4 and R9: refill order, no writes from a read miss
    rd_log_n = 0;
    wsnap = wr_log_n;
    do_access(1'b0, 32'h0005_0038, 32'h0, rdat, cyc, hit0);
    chk(rd_log_n == 4, "R4", "refill beat count", rd_log_n, 32'd4);
    for (int k = 0; k < 4; k++)
      chk(rd_log[k] == 32'h0005_0030 + 32'(4 * k), "R4", $sformatf("refill beat %0d address", k),
          rd_log[k], 32'h0005_0030 + 32'(4 * k));
    chk(wr_log_n == wsnap, "R9", "read miss caused no write", wr_log_n, wsnap);
    chk(rdat == ref_val(32'h0005_0038), "R3", "refilled word", rdat, ref_val(32'h0005_0038));

    // R5: one write-through per store hit
    wsnap = wr_log_n;
    do_access(1'b1, 32'h0005_0031, 32'h1234_5678, rdat, cyc, hit0);
    chk(wr_log_n == wsnap + 1, "R5", "write-through count", wr_log_n, wsnap + 1);
    chk(last_wr_addr == 32'h0005_0030, "R5", "write-through address", last_wr_addr, 32'h0005_0030);
    chk(last_wr_data == 32'h1234_5678, "R5", "write-through data", last_wr_data, 32'h1234_5678);

    // memory waits 3 cycles before each ready
    mem_lat = 3;
    do_access(1'b0, 32'h0006_0040, 32'h0, rdat, cyc, hit0);
    chk(cyc == 17, "R3", "read miss stall with wait", cyc, 32'd17);
    chk(rdat == ref_val(32'h0006_0040), "R3", "read miss data with wait", rdat, ref_val(32'h0006_0040));
    wsnap = wr_log_n;
    do_access(1'b1, 32'h0006_0044, 32'hCAFE_0003, rdat, cyc, hit0);
    chk(cyc == 3, "R5", "store hit waits for memory", cyc, 32'd3);
    chk(hit0 == 1'b1, "R5", "store hit flag while waiting", {31'd0, hit0}, 32'd1);
    chk(wr_log_n == wsnap + 1, "R5", "one write under wait", wr_log_n, wsnap + 1);
    do_access(1'b0, 32'h0006_0044, 32'h0, rdat, cyc, hit0);
    chk(cyc == 0 && rdat == 32'hCAFE_0003, "R5", "stored word reads back", rdat, 32'hCAFE_0003);
    do_access(1'b1, 32'h0007_0050, 32'hF00D_0004, rdat, cyc, hit0);
    chk(cyc == 20, "R6", "store miss stall with wait", cyc, 32'd20);
    chk(last_wr_data == 32'hF00D_0004, "R6", "store miss write-through", last_wr_data, 32'hF00D_0004);
    do_access(1'b0, 32'h0007_005C, 32'h0, rdat, cyc, hit0);
    chk(cyc == 0 && rdat == ref_val(32'h0007_005C), "R6", "neighbour word hits", rdat, ref_val(32'h0007_005C));
    @(negedge clk); #2;
    chk(mem_req == 1'b0, "R9", "mem_req idle after traffic", {31'd0, mem_req}, 32'd0);
    mem_lat = 0;

    // R8: reset forgets every line
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    do_access(1'b0, 32'h0001_001C, 32'h0, rdat, cyc, hit0);
    chk(cyc == 5, "R8", "line misses after reset", cyc, 32'd5);
    chk(hit0 == 1'b0, "R8", "no hit after reset", {31'd0, hit0}, 32'd0);
    chk(rdat == ref_val(32'h0001_001C), "R8", "data after reset refill", rdat, ref_val(32'h0001_001C));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule